// File: doc/BRIEF.md
# Priority-Then-Weighted Token Arbiter

This block decides which of several DMA channels may use a shared memory bus for its next burst. Priority is compared first. Among the requesters tied at the highest priority, weighted mode gives the bus only to channels that still have tokens. A channel's token count is refilled from its 4-bit weight. As a result, channels at the same level share bandwidth in proportion to their weights over a long run. A weight of zero shuts a channel out entirely while weighted mode is on. When weighted mode is off, the block is a plain priority arbiter with round-robin tie breaking.

The grant is one-hot and covers one whole burst. It is issued one clock after an idle cycle in which a candidate exists. It stays unchanged until the granted requester pulses `burst_done`, and it drops on the next edge. The bus is then idle for one cycle before the next grant. A granted burst always completes one token. Weights are written one channel at a time through a small write port that rejects out-of-range values. The ports are plain control pins with no valid/ready handshake: `req` is a level, and `burst_done` is the only completion signal.

Top module: `wtok_arbiter`

## Requirements
- R1: After reset the grant is all zero, every weight is 1 and every token count is 1, so two equal-priority channels in weighted mode receive equal shares without any weight write.
- R2: A weight write whose 5-bit data exceeds 15 is discarded, and the channel keeps its previous weight. A write of 0 to 15 is stored.
- R3: With weighted mode on, a channel whose weight is 0 is never granted, even when it is the only requester. With weighted mode off, the same channel is granted normally.
- R4: Priority is compared before tokens. A larger priority value wins. A requester at the highest priority is granted even when its tokens are spent, and lower-priority requesters receive nothing while it keeps requesting.
- R5: In weighted mode, equal-priority requesters that always request receive bursts in proportion to their weights. With weights 2, 3 and 4, the shares over 180 bursts are within 4 bursts of 40, 60 and 80.
- R6: With weights 15 and 1 at equal priority, the weight-15 channel receives more than ten times as many bursts as the weight-1 channel.
- R7: The grant is one-hot or zero. Once issued, it stays unchanged until `burst_done` is sampled high, even if other requests change. It clears on that edge.
- R8: With weighted mode off, weights and tokens have no effect. Equal-priority requesters alternate regardless of their weights.
- R9: Ties among candidates are broken round-robin, starting from the channel after the last one granted. After reset the search starts at channel 0.
- R10: One burst consumes one token, counted when `burst_done` is sampled. When no requester at the winning level has tokens left, all tokens reload from the weights in the same cycle as the arbitration. The reload adds no idle cycle: a new grant always appears exactly two edges after the `burst_done` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wmode_en | input | 1 | 1 = weighted token arbitration, 0 = plain priority |
| req | input | N_CH | Per-channel request level |
| prio_flat | input | N_CH*PRIO_W | Per-channel priority; channel i in bits [i*PRIO_W +: PRIO_W]; larger wins |
| wgt_wr_en | input | 1 | Weight write strobe |
| wgt_wr_idx | input | IDX_W | Channel addressed by the write |
| wgt_wr_data | input | 5 | Weight value; writes above 15 are discarded |
| burst_done | input | 1 | Granted burst finished; sampled only while a grant is held |
| grant | output | N_CH | One-hot grant, held for the whole burst |

## Verification
A corrupted token count or weight register does not show up at the ports right away. It first shows as a skewed burst share across a full reload round. That can take up to the sum of the weights in bursts, which is why long proportional runs are checked against computed counts. A wrong round-robin pointer shows on the very next grant, as an out-of-order channel index. A broken reload shows as an extra idle cycle between bursts or a missing grant, both visible within two cycles of the exhaustion. Hold and zero-weight faults show in the cycle after the offending edge.

// File: rtl/wtok_pkg.sv
package wtok_pkg;
  localparam int WGT_W   = 4;
  localparam int WGT_MAX = (1 << WGT_W) - 1;
  localparam int WR_W    = WGT_W + 1;
  typedef logic [WGT_W-1:0] wgt_t;
endpackage

// File: rtl/wtok_wgt_regs.sv
module wtok_wgt_regs
  import wtok_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [WR_W-1:0]       wr_data,
  output logic [N_CH*WGT_W-1:0] wgt_flat
);
  logic in_range;
  assign in_range = (int'(wr_data) <= WGT_MAX) && (int'(wr_idx) < N_CH);

  for (genvar c = 0; c < N_CH; c++) begin : g_wgt
    always_ff @(posedge clk) begin
      if (!rst_n)
        wgt_flat[c*WGT_W +: WGT_W] <= wgt_t'(1);
      else if (wr_en && in_range && (int'(wr_idx) == c))
        wgt_flat[c*WGT_W +: WGT_W] <= wr_data[WGT_W-1:0];
    end
  end

  AST_WR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_data) > WGT_MAX) |=> $stable(wgt_flat)); // R2
endmodule

// File: rtl/wtok_level_sel.sv
module wtok_level_sel #(
  parameter int N_CH   = 4,
  parameter int PRIO_W = 2
) (
  input  logic [N_CH-1:0]        mask,
  input  logic [N_CH*PRIO_W-1:0] prio_flat,
  output logic [N_CH-1:0]        level
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    best = '0;
    for (int i = 0; i < N_CH; i++)
      if (mask[i] && prio_flat[i*PRIO_W +: PRIO_W] > best)
        best = prio_flat[i*PRIO_W +: PRIO_W];
    for (int i = 0; i < N_CH; i++)
      level[i] = mask[i] && (prio_flat[i*PRIO_W +: PRIO_W] == best);
  end
endmodule

// File: rtl/wtok_rr_pick.sv
module wtok_rr_pick #(
  parameter int N_CH  = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_CH-1:0]  cand,
  input  logic [IDX_W-1:0] last_idx,
  output logic [N_CH-1:0]  pick_oh,
  output logic [IDX_W-1:0] pick_idx
);
  always_comb begin
    logic found;
    found    = 1'b0;
    pick_oh  = '0;
    pick_idx = '0;
    for (int k = 1; k <= N_CH; k++) begin
      int j;
      j = (int'(last_idx) + k) % N_CH;
      if (!found && cand[j]) begin
        found       = 1'b1;
        pick_oh[j]  = 1'b1;
        pick_idx    = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/wtok_arbiter.sv
module wtok_arbiter
  import wtok_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int PRIO_W = 2,
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wmode_en,
  input  logic [N_CH-1:0]        req,
  input  logic [N_CH*PRIO_W-1:0] prio_flat,
  input  logic                   wgt_wr_en,
  input  logic [IDX_W-1:0]       wgt_wr_idx,
  input  logic [WR_W-1:0]        wgt_wr_data,
  input  logic                   burst_done,
  output logic [N_CH-1:0]        grant
);
  logic [N_CH*WGT_W-1:0] wgt_flat;
  wgt_t                  tok_q [N_CH];
  logic [N_CH-1:0]       grant_q, wgt_zero, tok_nz;
  logic [N_CH-1:0]       eligible, level, with_tok, cand, pick_oh;
  logic [IDX_W-1:0]      last_q, pick_idx;
  logic                  busy, need_reload;

  wtok_wgt_regs #(.N_CH(N_CH), .IDX_W(IDX_W)) u_wgt (
    .clk(clk), .rst_n(rst_n), .wr_en(wgt_wr_en), .wr_idx(wgt_wr_idx),
    .wr_data(wgt_wr_data), .wgt_flat(wgt_flat)
  );

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      wgt_zero[i] = (wgt_flat[i*WGT_W +: WGT_W] == '0);
      tok_nz[i]   = (tok_q[i] != '0);
    end
  end

  assign busy     = |grant_q;
  assign eligible = wmode_en ? (req & ~wgt_zero) : req;

  wtok_level_sel #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_lvl (
    .mask(eligible), .prio_flat(prio_flat), .level(level)
  );

  assign with_tok    = level & tok_nz;
  assign need_reload = wmode_en && (|level) && !(|with_tok);
  assign cand        = !wmode_en ? level : (need_reload ? level : with_tok);

  wtok_rr_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_rr (
    .cand(cand), .last_idx(last_q), .pick_oh(pick_oh), .pick_idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= IDX_W'(N_CH - 1);
      for (int i = 0; i < N_CH; i++) tok_q[i] <= wgt_t'(1);
    end else if (!busy) begin
      if (|cand) begin
        grant_q <= pick_oh;
        last_q  <= pick_idx;
        if (need_reload)
          for (int i = 0; i < N_CH; i++) tok_q[i] <= wgt_flat[i*WGT_W +: WGT_W];
      end
    end else if (burst_done) begin
      grant_q <= '0;
      if (wmode_en && tok_q[last_q] != '0)
        tok_q[last_q] <= tok_q[last_q] - wgt_t'(1);
    end
  end

  assign grant = grant_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q)); // R7
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !burst_done) |=> $stable(grant_q)); // R7
  AST_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((grant_q & ~$past(req)) == '0)); // R4
  AST_ZERO_WGT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wmode_en) |=> ((grant_q & $past(wgt_zero)) == '0)); // R3
endmodule

// File: tb/wtok_arbiter_tb_top.sv
`timescale 1ns/1ps
module wtok_arbiter_tb_top;
  logic       clk = 0;
  logic       rst_n, wmode_en, wgt_wr_en, burst_done;
  logic [3:0] req, grant;
  logic [7:0] prio_flat;
  logic [1:0] wgt_wr_idx;
  logic [4:0] wgt_wr_data;

  int checks = 0, fails = 0;
  int cnt [4];
  int seq [400];

  always #2 clk = ~clk;

  wtok_arbiter #(.N_CH(4), .PRIO_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wmode_en(wmode_en), .req(req), .prio_flat(prio_flat),
    .wgt_wr_en(wgt_wr_en), .wgt_wr_idx(wgt_wr_idx), .wgt_wr_data(wgt_wr_data),
    .burst_done(burst_done), .grant(grant)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int oh2idx(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic do_reset(input bit wm);
    rst_n = 0; wmode_en = wm; req = '0; prio_flat = '0;
    wgt_wr_en = 0; wgt_wr_idx = '0; wgt_wr_data = '0; burst_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_wgt(input int ch, input int val);
    wgt_wr_idx = 2'(ch); wgt_wr_data = 5'(val); wgt_wr_en = 1;
    @(negedge clk);
    wgt_wr_en = 0;
  endtask

  // serve nb bursts; returns largest number of negedges waited for a grant
  task automatic serve(input int nb, output int maxw, output bit bad_oh);
    maxw = 0; bad_oh = 0;
    for (int c = 0; c < 4; c++) cnt[c] = 0;
    for (int b = 0; b < nb; b++) begin
      int w = 0;
      while (grant == '0 && w < 20) begin @(negedge clk); w++; end
      if (w > maxw) maxw = w;
      if (!$onehot(grant)) begin bad_oh = 1; seq[b] = -1; end
      else begin seq[b] = oh2idx(grant); cnt[seq[b]]++; end
      burst_done = 1;
      @(negedge clk);
      burst_done = 0;
    end
  endtask

  task automatic t_reset_defaults;
    int mw; bit boh;
    do_reset(1);
    chk(grant == '0, "R1 grant after reset", int'(grant), 0);
    req = 4'b0011;
    serve(40, mw, boh);
    chk(cnt[0] == 20 && cnt[1] == 20, "R1 default weight share ch0", cnt[0], 20);
    chk(mw == 1, "R10 no bubble with default weights", mw, 1);
  endtask

  task automatic t_write_reject;
    int mw; bit boh;
    do_reset(1);
    wr_wgt(2, 5);
    wr_wgt(2, 16);
    wr_wgt(2, 31);
    req = 4'b1100;
    serve(60, mw, boh);
    chk(cnt[2] >= 45, "R2 out-of-range write discarded, ch2 bursts", cnt[2], 50);
  endtask

  task automatic t_zero_weight;
    int mw; bit boh;
    do_reset(1);
    wr_wgt(0, 0);
    req = 4'b0011;
    serve(20, mw, boh);
    chk(cnt[0] == 0 && cnt[1] == 20, "R3 zero weight with rival, ch0 bursts", cnt[0], 0);
    while (grant != '0) @(negedge clk);
    req = 4'b0001;
    repeat (10) @(negedge clk);
    chk(grant == '0, "R3 zero weight alone not granted", int'(grant), 0);
    wmode_en = 0;
    repeat (2) @(negedge clk);
    chk(grant == 4'b0001, "R3 plain mode grants zero weight", int'(grant), 1);
  endtask

  task automatic t_priority;
    int mw; bit boh;
    do_reset(1);
    wr_wgt(1, 15);
    prio_flat = 8'b0000_0001; // ch0 prio 1, ch1 prio 0
    req = 4'b0011;
    serve(20, mw, boh);
    chk(cnt[0] == 20, "R4 high priority with weight 1 keeps bus", cnt[0], 20);
    chk(cnt[1] == 0, "R4 lower priority starved", cnt[1], 0);
  endtask

  task automatic t_proportion;
    int mw; bit boh;
    do_reset(1);
    wr_wgt(0, 2); wr_wgt(1, 3); wr_wgt(2, 4);
    req = 4'b0111;
    serve(180, mw, boh);
    chk(cnt[0] >= 36 && cnt[0] <= 44, "R5 weight 2 share", cnt[0], 40);
    chk(cnt[1] >= 56 && cnt[1] <= 64, "R5 weight 3 share", cnt[1], 60);
    chk(cnt[2] >= 76 && cnt[2] <= 84, "R5 weight 4 share", cnt[2], 80);
    chk(mw == 1, "R10 reload without idle cycle", mw, 1);
    chk(!boh, "R7 one-hot grant during weighted run", int'(boh), 0);
  endtask

  task automatic t_fifteen_vs_one;
    int mw; bit boh;
    do_reset(1);
    wr_wgt(1, 15);
    req = 4'b0011;
    serve(320, mw, boh);
    chk(cnt[1] > 10 * cnt[0] && cnt[0] > 0, "R6 weight 15 over weight 1", cnt[1], 10 * cnt[0] + 1);
  endtask

  task automatic t_hold;
    do_reset(1);
    req = 4'b0010;
    repeat (2) @(negedge clk);
    chk(grant == 4'b0010, "R7 grant issued to ch1", int'(grant), 2);
    prio_flat = 8'b0000_0011;
    req = 4'b0011;
    repeat (5) @(negedge clk);
    chk(grant == 4'b0010, "R7 grant held without burst_done", int'(grant), 2);
    burst_done = 1;
    @(negedge clk);
    burst_done = 0;
    chk(grant == '0, "R7 grant clears after burst_done", int'(grant), 0);
    @(negedge clk);
    chk(grant == 4'b0001, "R10 next grant two edges after done", int'(grant), 1);
  endtask

  task automatic t_plain_rr;
    int mw; bit boh; bit ok;
    do_reset(0);
    wr_wgt(0, 1); wr_wgt(1, 15);
    req = 4'b0011;
    serve(100, mw, boh);
    chk(cnt[0] == 50 && cnt[1] == 50, "R8 plain mode ignores weights, ch0", cnt[0], 50);
    while (grant != '0) @(negedge clk);
    do_reset(0);
    req = 4'b1111;
    serve(6, mw, boh);
    ok = 1;
    for (int b = 0; b < 6; b++) if (seq[b] != b % 4) ok = 0;
    chk(ok, "R9 round-robin order from ch0", seq[4], 0);
    while (grant != '0) @(negedge clk);
    do_reset(1);
    req = 4'b1010;
    serve(4, mw, boh);
    chk(seq[0] == 1 && seq[1] == 3 && seq[2] == 1, "R9 weighted rr skips idle channels", seq[1], 3);
  endtask

  initial begin
    t_reset_defaults();
    t_write_reject();
    t_zero_weight();
    t_priority();
    t_proportion();
    t_fifteen_vs_one();
    t_hold();
    t_plain_rr();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule